// File: doc/BRIEF.md
# One-Time-Programmable Word Store Device Model

This block is a synthesizable behavioural model of a 16-bit-wide programmable read-only memory as seen from its pins. It can sit opposite a memory controller in a testbench or in an emulation build. The model holds a parameterised number of 16-bit words. Each word starts as all ones. A programming operation can only clear bits. A synchronous erase input sets every word back to all ones.

Each clock edge the model samples its controls: an active-low chip select, an active-low output enable, an active-low program strobe, a flag meaning "programming voltage present" and a flag meaning "identifier voltage applied". From these it picks one of several modes: read, output disable, standby, program, program inhibit, program verify or identifier. The data output and its drive enable are registered. A result therefore appears one clock after the inputs that caused it. A tristate pad outside the block uses the enable. In identifier mode the model returns one of two fixed codes, each with odd parity. It raises an error flag if the upper address bits are not all zero at that time.

Top module: `otp_word_store`

## Requirements
- R1: Read. With `sel_n`=0 and `oe_n`=0, no program cycle, and `id_hv`=0, the edge drives `dout` with the word at `addr` and sets `dout_en`=1. A word that has been erased reads as 16'hFFFF.
- R2: Output disable. With `sel_n`=0, `oe_n`=1 and no program cycle, the edge clears `dout_en` and forces `dout` to 0.
- R3: Standby and inhibit. With `sel_n`=1, the edge clears `dout_en` and forces `dout` to 0, whatever `oe_n` is. No word changes, even when `prog_hv`=1 and `prog_n`=0.
- R4: Program. With `sel_n`=0, `prog_hv`=1 and `prog_n`=0, the edge stores (old word AND `din`) at `addr` and clears `dout_en`. This applies whatever `oe_n` is.
- R5: Verify. With `sel_n`=0, `prog_hv`=1, `prog_n`=1, `oe_n`=0 and `id_hv`=0, the edge drives the stored word. A word written by the program cycle just before is visible here.
- R6: Identifier. With `sel_n`=0, `oe_n`=0, `id_hv`=1 and no program cycle, the edge drives `dout`=16'h0001 when `addr[0]`=0 and 16'h0098 when `addr[0]`=1. The upper byte is zero. This mode takes priority over read and verify.
- R7: Both identifier bytes have odd parity over `dout[7:0]`, with bit 7 as the parity bit.
- R8: Programming never turns a 0 bit back to 1. `erase`=1 sets every word to 16'hFFFF at the edge and takes priority over a program cycle in the same clock.
- R9: `id_err` is 1 after an identifier edge whose `addr[ADDR_W-1:1]` is not zero. After every other edge it is 0.
- R10: While `rst_n`=0 at an edge, `dout`=0, `dout_en`=0 and `id_err`=0 afterwards, and every word becomes 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| erase | input | 1 | Synchronous set of all words to ones |
| sel_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program strobe |
| prog_hv | input | 1 | Programming voltage present |
| id_hv | input | 1 | Identifier voltage applied to the address pin |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Data to program |
| dout | output | 16 | Registered output data |
| dout_en | output | 1 | Drive enable for the output pads |
| id_err | output | 1 | Identifier cycle with upper address bits not zero |

## Verification
The in-RTL assertions check the following on every cycle:
- The drive enable follows the decoded mode for standby, output disable, program and read.
- Identifier output has a zero upper byte and odd parity in the lower byte.
- A stored word never gains a one bit except through erase.
- Erase leaves all ones.

Three behaviours depend on values carried across cycles, so only the bench's scenarios can show them:
- The exact contents returned after a chain of programs.
- Inhibit leaving a word untouched.
- Erase winning over a program in the same clock.

The bench's reference model and its directed checks cover these.

// File: rtl/otp_pkg.sv
// Shared types for the word store model.
// Assumes: the decoder emits exactly one mode per cycle.
package otp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_DISABLE,
        MD_PROGRAM,
        MD_READ,
        MD_VERIFY,
        MD_IDENT
    } dev_mode_t;

    // Builds an 8-bit identifier with bit 7 chosen for odd parity.
    function automatic logic [7:0] odd_parity_code(input logic [6:0] payload);
        return {~(^payload), payload};
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
// Decodes pin levels into one device mode. Purely combinational.
// Priority: select, then program, then output enable, then identifier.
// Assumes: inputs are already synchronous to the model clock.
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      sel_n,
    input  logic      oe_n,
    input  logic      prog_n,
    input  logic      prog_hv,
    input  logic      id_hv,
    output dev_mode_t mode,
    output logic      wr_req
);

    // Mode selection by fixed priority.
    always_comb begin
        if (sel_n) begin
            mode = prog_hv ? MD_INHIBIT : MD_STANDBY;
        end else if (prog_hv && !prog_n) begin
            mode = MD_PROGRAM;
        end else if (oe_n) begin
            mode = MD_DISABLE;
        end else if (id_hv) begin
            mode = MD_IDENT;
        end else if (prog_hv) begin
            mode = MD_VERIFY;
        end else begin
            mode = MD_READ;
        end
    end

    // Write strobe for the array.
    always_comb wr_req = (mode == MD_PROGRAM);

endmodule

// File: rtl/otp_cell_array.sv
// Word array where a write can only clear bits.
// Erase and reset set every word to ones; erase beats a write.
// Read is combinational from the current address (old value at an edge).
module otp_cell_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Erase to ones or AND the new word into the old one.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[addr] <= cells[addr] & wdata;
        end
    end

    // Read port.
    always_comb rd_data = cells[addr];

    // R8
    bits_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase) |=> ((cells[$past(addr)] & ~$past(rd_data)) == '0));

    // R8
    erase_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (rd_data == {DATA_W{1'b1}}));

endmodule

// File: rtl/otp_out_stage.sv
// Registered output mux. It drives the array word, the identifier code or zero.
// It also registers the identifier address error.
// Assumes: the mode is decoded from the same cycle's inputs.
module otp_out_stage
    import otp_pkg::*;
#(
    parameter int         DATA_W  = 16,
    parameter logic [6:0] MFR_ID7 = 7'h01,
    parameter logic [6:0] DEV_ID7 = 7'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dev_mode_t         mode,
    input  logic              addr_lsb,
    input  logic              addr_hi_nz,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              id_err
);

    localparam logic [7:0] MFR_CODE = odd_parity_code(MFR_ID7);
    localparam logic [7:0] DEV_CODE = odd_parity_code(DEV_ID7);

    logic [DATA_W-1:0] nxt_data;
    logic              nxt_en;
    logic              id_q;

    // Next output value per mode.
    always_comb begin
        nxt_data = '0;
        nxt_en   = 1'b0;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                nxt_data = rd_data;
                nxt_en   = 1'b1;
            end
            MD_IDENT: begin
                nxt_data = {{(DATA_W-8){1'b0}}, (addr_lsb ? DEV_CODE : MFR_CODE)};
                nxt_en   = 1'b1;
            end
            default: begin
                nxt_data = '0;
                nxt_en   = 1'b0;
            end
        endcase
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
            id_err  <= 1'b0;
            id_q    <= 1'b0;
        end else begin
            dout    <= nxt_data;
            dout_en <= nxt_en;
            id_err  <= (mode == MD_IDENT) && addr_hi_nz;
            id_q    <= (mode == MD_IDENT);
        end
    end

    // R7
    id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_q |-> (^dout[7:0]));

    // R6
    id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_q |-> (dout_en && dout[DATA_W-1:8] == '0));

    // R9
    id_err_only_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |-> id_q);

endmodule

// File: rtl/otp_word_store.sv
// Top of the word store device model.
// The decoder, the bit-clearing array and the registered output stage are
// joined here. Assumes ADDR_W >= 2 and a data width of 16 bits.
module otp_word_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              sel_n,
    input  logic              oe_n,
    input  logic              prog_n,
    input  logic              prog_hv,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic              dout_en,
    output logic              id_err
);
    import otp_pkg::*;

    localparam int DATA_W = 16;

    dev_mode_t         mode;
    logic              wr_req;
    logic [DATA_W-1:0] rd_data;
    logic              addr_hi_nz;

    // Upper address bits must be zero in identifier mode.
    always_comb addr_hi_nz = |addr[ADDR_W-1:1];

    otp_mode_decode u_dec (
        .sel_n   (sel_n),
        .oe_n    (oe_n),
        .prog_n  (prog_n),
        .prog_hv (prog_hv),
        .id_hv   (id_hv),
        .mode    (mode),
        .wr_req  (wr_req)
    );

    otp_cell_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_req),
        .addr    (addr),
        .wdata   (din),
        .rd_data (rd_data)
    );

    otp_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .addr_lsb   (addr[0]),
        .addr_hi_nz (addr_hi_nz),
        .rd_data    (rd_data),
        .dout       (dout),
        .dout_en    (dout_en),
        .id_err     (id_err)
    );

    // R3
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (!dout_en && dout == '0));

    // R4
    program_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && prog_hv && !prog_n) |=> !dout_en);

    // R2
    disable_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && oe_n) |=> !dout_en);

    // R1
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !oe_n && !(prog_hv && !prog_n)) |=> dout_en);

endmodule

// File: tb/sim_otp_word_store.sv
module sim_otp_word_store;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          erase = 1'b0;
    logic          sel_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          prog_n = 1'b1;
    logic          prog_hv = 1'b0;
    logic          id_hv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic          dout_en;
    logic          id_err;

    int checks = 0;
    int fails  = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    // Reference state.
    logic [15:0] ref_mem [DEPTH];
    logic [15:0] exp_d;
    logic        exp_en;
    logic        exp_err;
    logic        exp_id;
    string       exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_word_store #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .erase(erase), .sel_n(sel_n), .oe_n(oe_n),
        .prog_n(prog_n), .prog_hv(prog_hv), .id_hv(id_hv), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en), .id_err(id_err)
    );

    // Behavioural reference, updated at each rising edge.
    always @(posedge clk) begin
        logic [15:0] w;
        armed <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] <= 16'hFFFF;
            exp_d <= 16'h0; exp_en <= 1'b0; exp_err <= 1'b0; exp_id <= 1'b0;
            exp_tag <= "R10";
        end else begin
            w = ref_mem[addr];
            exp_d <= 16'h0; exp_en <= 1'b0; exp_err <= 1'b0; exp_id <= 1'b0;
            if (sel_n) begin
                exp_tag <= "R3";
            end else if (prog_hv && !prog_n) begin
                exp_tag <= "R4";
            end else if (oe_n) begin
                exp_tag <= "R2";
            end else if (id_hv) begin
                exp_tag <= "R6/R9";
                exp_en  <= 1'b1;
                exp_id  <= 1'b1;
                exp_d   <= addr[0] ? 16'h0098 : 16'h0001;
                exp_err <= (addr >> 1) != 0;
            end else begin
                exp_tag <= prog_hv ? "R5" : "R1";
                exp_en  <= 1'b1;
                exp_d   <= w;
            end
            if (erase) begin
                for (int i = 0; i < DEPTH; i++) ref_mem[i] <= 16'hFFFF;
            end else if (!sel_n && prog_hv && !prog_n) begin
                ref_mem[addr] <= w & din;
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (dout !== exp_d || dout_en !== exp_en || id_err !== exp_err) begin
                fails++;
                $display("FAIL %s: dout=%h en=%b err=%b expected dout=%h en=%b err=%b",
                         exp_tag, dout, dout_en, id_err, exp_d, exp_en, exp_err);
            end
            if (exp_id) begin
                // R7: odd parity over the low byte
                checks++;
                if ((^dout[7:0]) !== 1'b1) begin
                    fails++;
                    $display("FAIL R7: low byte %h parity %b expected 1", dout[7:0], ^dout[7:0]);
                end
            end
        end
    end

    task automatic step(input logic s, input logic o, input logic p, input logic hp,
                        input logic hi, input int a, input logic [15:0] d, input logic e);
        sel_n = s; oe_n = o; prog_n = p; prog_hv = hp; id_hv = hi;
        addr = AW'(a); din = d; erase = e;
        @(negedge clk);
    endtask

    task automatic want(input string tag, input logic [15:0] d, input logic en);
        checks++;
        if (dout !== d || dout_en !== en) begin
            fails++;
            $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b", tag, dout, dout_en, d, en);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        want("R10", 16'h0, 1'b0);                       // R10 reset state
        rst_n = 1'b1;
        step(0, 0, 1, 0, 0, 5, 0, 0);   want("R1", 16'hFFFF, 1'b1);    // R1 erased read
        step(0, 1, 0, 1, 0, 5, 16'h1234, 0); want("R4", 16'h0, 1'b0);  // R4 program
        step(0, 0, 1, 0, 0, 5, 0, 0);   want("R1", 16'h1234, 1'b1);
        step(0, 1, 0, 1, 0, 5, 16'hFFF0, 0);                           // R8 second pulse
        step(0, 0, 1, 1, 0, 5, 0, 0);   want("R8", 16'h1230, 1'b1);    // R5 verify view
        step(0, 1, 1, 1, 0, 5, 0, 0);   want("R5", 16'h0, 1'b0);
        step(0, 0, 1, 1, 0, 5, 0, 0);   want("R5", 16'h1230, 1'b1);
        step(0, 1, 1, 0, 0, 5, 0, 0);   want("R2", 16'h0, 1'b0);       // R2 disable
        step(1, 0, 0, 1, 0, 7, 16'h0000, 0); want("R3", 16'h0, 1'b0);  // R3 inhibit
        step(0, 0, 1, 0, 0, 7, 0, 0);   want("R3", 16'hFFFF, 1'b1);
        step(0, 0, 1, 0, 1, 0, 0, 0);   want("R6", 16'h0001, 1'b1);    // R6 maker code
        step(0, 0, 1, 0, 1, 1, 0, 0);   want("R6", 16'h0098, 1'b1);    // R6 part code
        step(0, 0, 1, 0, 1, 6, 0, 0);   want("R9", 16'h0001, 1'b1);    // R9 flag
        step(0, 1, 0, 1, 0, 9, 16'h00FF, 1);                           // R8 erase beats program
        step(0, 0, 1, 0, 0, 9, 0, 0);   want("R8", 16'hFFFF, 1'b1);
        step(0, 0, 1, 0, 0, 5, 0, 0);   want("R8", 16'hFFFF, 1'b1);
        for (int n = 0; n < 600; n++) begin
            step(($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 3) != 0,
                 ($urandom % 2) == 0, ($urandom % 6) == 0,
                 (($urandom % 8) == 0) ? int'($urandom % DEPTH) : int'($urandom % 8),
                 16'($urandom), ($urandom % 60) == 0);
        end
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule